// File: doc/BRIEF.md
# Selectable-Source Clock Output Divider

This block produces one divided clock output for a pin. It takes two source rates, each arriving as a one-cycle enable pulse in the system clock domain: a slow 32768 Hz tick and a fast tick of roughly 4 MHz. An 8-bit control register chooses the source and sets the division. When the fast source is chosen, a pre-divider with a non-uniform ratio table is applied first, followed by a power-of-two post-divider. When the slow source is chosen, the pre-divider is skipped. An enable bit gates the output.

The register is written through a simple write strobe and can always be read back. A chip that needs several output pins places several copies of this channel at consecutive register addresses. Address decoding lives outside the block.

The output is a flop that toggles each time the combined divider reaches its terminal count. The full output period is therefore twice the total division, and the duty cycle is always 50%.

Top module: `clkout_channel`

## Requirements
- R1: When control bit 0 (enable) is 0, `clk_out` is held at 0 and source ticks have no effect on it.
- R2: Control bits 3:1 hold the post-divider code c. The post-divider divides its input tick rate by 2^c, which gives 1, 2, 4 and so on up to 128.
- R3: Control bit 4 selects the source: 0 means `slow_tick` and 1 means `fast_tick`. Ticks on the source that is not selected are ignored.
- R4: With the fast source selected, control bits 7:5 hold the pre-divider code p. Codes 0 to 6 divide by 2^p (1 to 64), and code 7 divides by 122.
- R5: With the slow source selected, the pre-divider code has no effect, and the division is the post-divider alone.
- R6: While enabled, `clk_out` inverts at the clock edge that samples every P·D-th selected tick since the last write. P is the pre-divider ratio (1 on the slow path) and D is 2^c. The first inversion after a write takes the output high.
- R7: Every register write restarts both divider counters and drives `clk_out` to 0. A tick sampled in the same cycle as the write is not counted.
- R8: `reg_rdata` returns all 8 bits of the last value written, starting in the cycle after the write.
- R9: After reset, the control register reads 0x00 and `clk_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable pulse at the slow source rate |
| fast_tick | input | 1 | One-cycle enable pulse at the fast source rate |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Control value to write |
| reg_rdata | output | 8 | Current control register contents |
| clk_out | output | 1 | Divided, gated clock output |

## Verification
A wrong count in either divider shows up at `clk_out` as an edge on the wrong tick. This is visible within one half-period of P·D selected ticks, so the bench compares the output after every single cycle. A control field latched into the wrong bit position shows up on readback in the very next cycle. It also shows up as a wrong ratio by the first expected toggle. Ratio code 7 and the slow-path bypass are run long enough to cover several toggles, so an off-by-one in the terminal count accumulates into a visible mismatch.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int CTRL_W      = 8;
    localparam int PRE_CODE_W  = 3;
    localparam int POST_CODE_W = 3;
    localparam int LAST_PRE    = 122;
    localparam int PRE_CNT_W   = $clog2(LAST_PRE);
    localparam int POST_CNT_W  = (1 << POST_CODE_W) - 1;

    typedef struct packed {
        logic [PRE_CODE_W-1:0]  pre_code;
        logic                   fast_sel;
        logic [POST_CODE_W-1:0] post_code;
        logic                   enable;
    } ctrl_t;

    function automatic logic [PRE_CNT_W-1:0] pre_last(input logic [PRE_CODE_W-1:0] code);
        logic [PRE_CNT_W-1:0] r;
        if (code == {PRE_CODE_W{1'b1}})
            r = PRE_CNT_W'(LAST_PRE - 1);
        else
            r = PRE_CNT_W'((1 << code) - 1);
        return r;
    endfunction

    function automatic logic [POST_CNT_W-1:0] post_last(input logic [POST_CODE_W-1:0] code);
        return POST_CNT_W'((1 << code) - 1);
    endfunction

endpackage

// File: rtl/clkout_prediv.sv
module clkout_prediv
    import clkout_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  bypass,
    input  logic [PRE_CODE_W-1:0] code,
    input  logic                  tick_in,
    output logic                  tick_out
);
    logic [PRE_CNT_W-1:0] cnt;
    logic [PRE_CNT_W-1:0] last;

    assign last = pre_last(code);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (tick_in && !bypass)
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end

    assign tick_out = bypass ? tick_in : (tick_in && (cnt == last));

    // R4: the pre-divider count never passes the selected ratio
    p_pre_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

    // R5: while bypassed the counter does not advance
    p_pre_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (bypass && !clear) |=> $stable(cnt));

endmodule

// File: rtl/clkout_postdiv.sv
module clkout_postdiv
    import clkout_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic [POST_CODE_W-1:0] code,
    input  logic                   tick_in,
    output logic                   terminal
);
    logic [POST_CNT_W-1:0] cnt;
    logic [POST_CNT_W-1:0] last;

    assign last = post_last(code);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (tick_in)
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end

    assign terminal = tick_in && (cnt == last);

    // R2: the post-divider count stays below 2^code
    p_post_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

endmodule

// File: rtl/clkout_channel.sv
module clkout_channel
    import clkout_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic              clk_out
);
    ctrl_t ctrl;
    logic  src_tick;
    logic  stage_tick;
    logic  wrap;
    logic  restart;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (reg_wr)
            ctrl <= ctrl_t'(reg_wdata);
    end

    assign reg_rdata = ctrl;
    assign src_tick  = ctrl.fast_sel ? fast_tick : slow_tick;
    assign restart   = reg_wr || !ctrl.enable;

    clkout_prediv u_pre (
        .clk      (clk),
        .rst      (rst),
        .clear    (restart),
        .bypass   (!ctrl.fast_sel),
        .code     (ctrl.pre_code),
        .tick_in  (src_tick),
        .tick_out (stage_tick)
    );

    clkout_postdiv u_post (
        .clk      (clk),
        .rst      (rst),
        .clear    (restart),
        .code     (ctrl.post_code),
        .tick_in  (stage_tick),
        .terminal (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst || restart)
            clk_out <= 1'b0;
        else if (wrap)
            clk_out <= ~clk_out;
    end

    // R1: a disabled channel drives its output low
    p_gate_low_r1: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |-> !clk_out);

    // R7: a write always leaves the output low
    p_write_restart_r7: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !clk_out);

    // R3: without a selected tick and without a write the output holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!src_tick && !reg_wr) |=> $stable(clk_out));

    // R8: readback shows the written value in the next cycle
    p_readback_r8: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata == $past(reg_wdata)));

endmodule

// File: tb/clkout_channel_test.sv
module clkout_channel_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_tick = 1'b0;
    logic       fast_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       clk_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_ctrl = 8'h00;
    int m_n = 0;

    always #5 clk = ~clk;

    clkout_channel uut (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out)
    );

    function automatic int pre_ratio(input logic [2:0] code);
        return (code == 3'd7) ? 122 : (1 << code);
    endfunction

    function automatic logic exp_out(input logic [7:0] c, input int n);
        int p;
        int d;
        if (!c[0]) return 1'b0;
        p = c[4] ? pre_ratio(c[7:5]) : 1;
        d = 1 << c[3:1];
        return logic'((n / (p * d)) % 2);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (ctrl=%0h n=%0d)", req, act, exp, m_ctrl, m_n);
        end
    endtask

    // Called at a negedge: drive one cycle, update the model, compare after the edge.
    task automatic cycle(input logic f, input logic s, input logic w, input logic [7:0] d,
                         input string req);
        fast_tick = f; slow_tick = s; reg_wr = w; reg_wdata = d;
        @(posedge clk);
        if (w) begin
            m_ctrl = d; m_n = 0;
        end else if (m_ctrl[0] && (m_ctrl[4] ? f : s)) begin
            m_n++;
        end
        @(negedge clk);
        fast_tick = 1'b0; slow_tick = 1'b0; reg_wr = 1'b0;
        check(req, {7'd0, clk_out}, {7'd0, exp_out(m_ctrl, m_n)});
        check("R8", reg_rdata, m_ctrl);
    endtask

    task automatic wr(input logic [7:0] d, input string req);
        cycle(1'b0, 1'b0, 1'b1, d, req);
    endtask

    // Ticks on the selected source every cycle; the other source toggles too.
    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++)
            cycle(1'b1, 1'b1, 1'b0, 8'h00, req);
    endtask

    task automatic run_other(input int n, input string req);
        for (int i = 0; i < n; i++)
            cycle(!m_ctrl[4], m_ctrl[4], 1'b0, 8'h00, req);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", {7'd0, clk_out}, 8'h00);
        check("R9", reg_rdata, 8'h00);

        // R1: disabled, all other fields set, ticks arrive
        wr(8'hFE, "R1");
        run(60, "R1");

        // R6: slow path, divide by 1: toggle on every tick
        wr(8'h01, "R6");
        run(10, "R6");

        // R3: unselected source ignored (slow selected, fast ticks only)
        wr(8'h03, "R3");
        run_other(20, "R3");
        run(6, "R3");

        // R5: slow path with pre code 7 set: division is post only (2)
        wr(8'hE3, "R5");
        run(20, "R5");

        // R4: fast path, pre code 7 -> 122
        wr(8'hF1, "R4");
        run(300, "R4");
        // R3: fast selected, slow ticks ignored
        run_other(30, "R3");

        // R4: fast path, pre code 3 (8), post code 2 (4)
        wr(8'h75, "R4");
        run(100, "R4");

        // R2: slow path, post code 7 -> 128
        wr(8'h0F, "R2");
        run(300, "R2");

        // R7: rewrite mid-run restarts; tick in the write cycle not counted
        wr(8'h13, "R7");
        run(3, "R7");
        cycle(1'b1, 1'b1, 1'b1, 8'h13, "R7");
        run(5, "R7");

        // R1: disabling mid-run forces low
        run(1, "R1");
        wr(8'h12, "R1");
        run(10, "R1");

        // random configurations with random tick patterns
        for (int k = 0; k < 60; k++) begin
            logic [7:0] v;
            v = 8'($urandom);
            if (($urandom % 4) != 0) v[0] = 1'b1;
            wr(v, "R6");
            for (int i = 0; i < 200; i++) begin
                int r;
                r = $urandom % 4;
                cycle(r[0], r[1], 1'b0, 8'h00, "R6");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule